// File: doc/BRIEF.md
# Grouped Register Bank for a Program-Driven Virtual Machine

This block is the architectural register storage of a virtual machine that executes generated programs. It holds eight 64-bit integer registers and twelve 128-bit floating-point registers. The floating-point registers sit in three banks of four. The *base* bank can be read at any time but is written only while a program is being loaded. The *accumulate* bank and the *product* bank are read and written freely. Each 128-bit register carries a pair of double values that always moves as one unit. A fifth addressing view, *mixed*, presents eight floating-point slots: indices 0-3 reach the accumulate bank and indices 4-7 reach the product bank.

The block has two combinational read ports and one synchronous write port. Every port selects a group with a 3-bit code and a register with a 3-bit index. A separate load port fills the base bank during the load phase. A 2-bit rounding-mode register is updated by its own strobe. A two-state fault machine reports a write to the base bank that was refused. Its states are `ST_CLEAN` (no fault) and `ST_FAULT` (fault reported this cycle). `ST_CLEAN -> ST_FAULT` is taken when a refused write occurs. `ST_FAULT -> ST_FAULT` is taken when another refused write follows at once. `ST_FAULT -> ST_CLEAN` is taken when the cycle is clean. Reset forces `ST_CLEAN`.

Top module: `vmregs_bank`

## Requirements
- R1: Group code 0 (integer) with index 0-7 reaches one of eight 64-bit registers. A write stores bits 63:0 of the write data. A read returns the value zero-extended to 128 bits.
- R2: Group codes 1 (base), 2 (accumulate) and 3 (product) each address four 128-bit registers. Only index bits 1:0 are used, so index bit 2 is ignored.
- R3: Group code 4 (mixed) maps index 0-3 to accumulate registers 0-3 and index 4-7 to product registers 0-3. Both views share the same storage.
- R4: A base register changes only while `load_mode` is 1. It can be changed through the load port or through the main write port with group 1. Either write is discarded while `load_mode` is 0.
- R5: Each cycle that contains a discarded base write makes `fault` high in the following cycle. `fault` is low after any cycle without one.
- R6: A read of the register being written in the same cycle returns the old value. The new value appears from the next cycle on.
- R7: A synchronous reset clears the integer, accumulate and product registers, the rounding mode and `fault`. Base registers keep their contents.
- R8: `rmode_q` takes `rmode_d` on a clock edge with `rmode_we` high and holds otherwise.
- R9: Group codes 5-7 read as zero, and a write that uses them changes no register.
- R10: When the main port and the load port write the same base register in one load-mode cycle, the main port's data is stored.
- R11: The two read ports resolve their selections independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_mode | input | 1 | Program-load phase; unlocks base bank writes |
| wr_en | input | 1 | Main write strobe |
| wr_grp | input | 3 | Main write group code |
| wr_idx | input | 3 | Main write index |
| wr_data | input | 128 | Main write data |
| ld_we | input | 1 | Load-port write strobe (base bank) |
| ld_idx | input | 2 | Load-port base register index |
| ld_data | input | 128 | Load-port data |
| rmode_we | input | 1 | Rounding-mode update strobe |
| rmode_d | input | 2 | New rounding mode |
| rd_grp0 | input | 3 | Read port 0 group code |
| rd_idx0 | input | 3 | Read port 0 index |
| rd_data0 | output | 128 | Read port 0 data |
| rd_grp1 | input | 3 | Read port 1 group code |
| rd_idx1 | input | 3 | Read port 1 index |
| rd_data1 | output | 128 | Read port 1 data |
| rmode_q | output | 2 | Current rounding mode |
| fault | output | 1 | One-cycle report of a discarded base write |

## Verification
A wrong slot decode shows up as a wrong value on a read port in the first cycle that the affected register is selected. A mixed-view index that goes to the wrong bank, for example, returns a value written through the other bank. A base register that takes a locked write keeps the wrong value indefinitely, and a later read of that register exposes it. A fault machine stuck in the wrong state shows on `fault` exactly one cycle after the triggering edge. Every cycle compares both read ports, `fault` and `rmode_q` against a model, so any corruption is reported the next time that register is read.

// File: rtl/vmrf_pkg.sv
package vmrf_pkg;
    typedef enum logic [2:0] {
        GRP_INT  = 3'd0,
        GRP_BASE = 3'd1,
        GRP_ACC  = 3'd2,
        GRP_PROD = 3'd3,
        GRP_MIX  = 3'd4
    } grp_e;

    typedef enum logic {
        ST_CLEAN = 1'b0,
        ST_FAULT = 1'b1
    } fault_st_e;
endpackage

// File: rtl/vmrf_decode.sv
module vmrf_decode #(
    parameter int NINT = 8,
    parameter int NFP  = 4,
    parameter int IW   = 3,
    parameter int FW   = 2,
    parameter int SW   = 5
) (
    input  logic [2:0]    grp,
    input  logic [IW-1:0] idx,
    output logic [SW-1:0] slot,
    output logic          hit,
    output logic          is_base
);
    import vmrf_pkg::*;

    localparam logic [SW-1:0] BASE0 = SW'(NINT);
    localparam logic [SW-1:0] ACC0  = SW'(NINT + NFP);
    localparam logic [SW-1:0] PROD0 = SW'(NINT + 2 * NFP);

    logic [SW-1:0] fp_off;
    assign fp_off = {{(SW-FW){1'b0}}, idx[FW-1:0]};

    always_comb begin
        slot    = '0;
        hit     = 1'b1;
        is_base = 1'b0;
        unique case (grp)
            GRP_INT:  slot = {{(SW-IW){1'b0}}, idx};
            GRP_BASE: begin
                slot    = BASE0 + fp_off;
                is_base = 1'b1;
            end
            GRP_ACC:  slot = ACC0 + fp_off;
            GRP_PROD: slot = PROD0 + fp_off;
            GRP_MIX:  slot = idx[FW] ? (PROD0 + fp_off) : (ACC0 + fp_off);
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vmrf_storage.sv
module vmrf_storage #(
    parameter int XLEN  = 64,
    parameter int FLEN  = 128,
    parameter int NINT  = 8,
    parameter int NFP   = 4,
    parameter int NSLOT = 20,
    parameter int SW    = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [SW-1:0]   wslot,
    input  logic [FLEN-1:0] wdata,
    input  logic            lwe,
    input  logic [SW-1:0]   lslot,
    input  logic [FLEN-1:0] ldata,
    input  logic [SW-1:0]   rslot0,
    input  logic [SW-1:0]   rslot1,
    output logic [FLEN-1:0] rdata0,
    output logic [FLEN-1:0] rdata1
);
    logic [FLEN-1:0] slot_q [NSLOT];

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        localparam logic [SW-1:0] ME = SW'(s);
        if (s < NINT) begin : g_int
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && wslot == ME)
                    q <= wdata[XLEN-1:0];
            end
            assign slot_q[s] = {{(FLEN-XLEN){1'b0}}, q};
        end else if (s < NINT + NFP) begin : g_base
            logic [FLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= q;
                else if (we && wslot == ME)
                    q <= wdata;
                else if (lwe && lslot == ME)
                    q <= ldata;
            end
            assign slot_q[s] = q;
        end else begin : g_fp
            logic [FLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (we && wslot == ME)
                    q <= wdata;
            end
            assign slot_q[s] = q;
        end
    end

    always_comb begin
        rdata0 = '0;
        rdata1 = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (rslot0 == SW'(s)) rdata0 = slot_q[s];
            if (rslot1 == SW'(s)) rdata1 = slot_q[s];
        end
    end
endmodule

// File: rtl/vmrf_fault_fsm.sv
module vmrf_fault_fsm (
    input  logic clk,
    input  logic rst,
    input  logic refused,
    output logic fault
);
    import vmrf_pkg::*;

    fault_st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_CLEAN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAN: if (refused)  state_nx = ST_FAULT;
            ST_FAULT: if (!refused) state_nx = ST_CLEAN;
            default:  state_nx = ST_CLEAN;
        endcase
    end

    always_comb begin
        fault = 1'b0;
        unique case (state)
            ST_CLEAN: fault = 1'b0;
            ST_FAULT: fault = 1'b1;
            default:  fault = 1'b0;
        endcase
    end
endmodule

// File: rtl/vmregs_bank.sv
module vmregs_bank #(
    parameter int XLEN = 64,
    parameter int NINT = 8,
    parameter int NFP  = 4,
    parameter int RMW  = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_mode,
    input  logic                         wr_en,
    input  logic [2:0]                   wr_grp,
    input  logic [$clog2(NINT)-1:0]      wr_idx,
    input  logic [2*XLEN-1:0]            wr_data,
    input  logic                         ld_we,
    input  logic [$clog2(NFP)-1:0]       ld_idx,
    input  logic [2*XLEN-1:0]            ld_data,
    input  logic                         rmode_we,
    input  logic [RMW-1:0]               rmode_d,
    input  logic [2:0]                   rd_grp0,
    input  logic [$clog2(NINT)-1:0]      rd_idx0,
    output logic [2*XLEN-1:0]            rd_data0,
    input  logic [2:0]                   rd_grp1,
    input  logic [$clog2(NINT)-1:0]      rd_idx1,
    output logic [2*XLEN-1:0]            rd_data1,
    output logic [RMW-1:0]               rmode_q,
    output logic                         fault
);
    localparam int FLEN  = 2 * XLEN;
    localparam int IW    = $clog2(NINT);
    localparam int FW    = $clog2(NFP);
    localparam int NSLOT = NINT + 3 * NFP;
    localparam int SW    = $clog2(NSLOT);
    localparam int NPORT = 3;

    logic [2:0]      p_grp  [NPORT];
    logic [IW-1:0]   p_idx  [NPORT];
    logic [SW-1:0]   p_slot [NPORT];
    logic            p_hit  [NPORT];
    logic            p_base [NPORT];

    assign p_grp[0] = wr_grp;
    assign p_idx[0] = wr_idx;
    assign p_grp[1] = rd_grp0;
    assign p_idx[1] = rd_idx0;
    assign p_grp[2] = rd_grp1;
    assign p_idx[2] = rd_idx1;

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        vmrf_decode #(.NINT(NINT), .NFP(NFP), .IW(IW), .FW(FW), .SW(SW)) u_dec (
            .grp     (p_grp[p]),
            .idx     (p_idx[p]),
            .slot    (p_slot[p]),
            .hit     (p_hit[p]),
            .is_base (p_base[p])
        );
    end

    logic main_ok, load_ok, refused;
    logic [SW-1:0] ld_slot;
    logic [FLEN-1:0] raw0, raw1;

    assign main_ok = wr_en && p_hit[0] && (!p_base[0] || load_mode);
    assign load_ok = ld_we && load_mode;
    assign refused = !load_mode && (ld_we || (wr_en && p_hit[0] && p_base[0]));
    assign ld_slot = SW'(NINT) + {{(SW-FW){1'b0}}, ld_idx};

    vmrf_storage #(
        .XLEN(XLEN), .FLEN(FLEN), .NINT(NINT), .NFP(NFP), .NSLOT(NSLOT), .SW(SW)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .we     (main_ok),
        .wslot  (p_slot[0]),
        .wdata  (wr_data),
        .lwe    (load_ok),
        .lslot  (ld_slot),
        .ldata  (ld_data),
        .rslot0 (p_slot[1]),
        .rslot1 (p_slot[2]),
        .rdata0 (raw0),
        .rdata1 (raw1)
    );

    assign rd_data0 = p_hit[1] ? raw0 : '0;
    assign rd_data1 = p_hit[2] ? raw1 : '0;

    vmrf_fault_fsm u_fault (
        .clk     (clk),
        .rst     (rst),
        .refused (refused),
        .fault   (fault)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rmode_q <= '0;
        else if (rmode_we)
            rmode_q <= rmode_d;
    end
endmodule

// File: rtl/vmrf_chk.sv
module vmrf_chk #(
    parameter int XLEN = 64,
    parameter int NINT = 8,
    parameter int NFP  = 4,
    parameter int RMW  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load_mode,
    input logic                    wr_en,
    input logic [2:0]              wr_grp,
    input logic [$clog2(NINT)-1:0] wr_idx,
    input logic [2*XLEN-1:0]       wr_data,
    input logic                    ld_we,
    input logic [$clog2(NFP)-1:0]  ld_idx,
    input logic [2*XLEN-1:0]       ld_data,
    input logic                    rmode_we,
    input logic [RMW-1:0]          rmode_d,
    input logic [2:0]              rd_grp0,
    input logic [$clog2(NINT)-1:0] rd_idx0,
    input logic [2*XLEN-1:0]       rd_data0,
    input logic [2:0]              rd_grp1,
    input logic [$clog2(NINT)-1:0] rd_idx1,
    input logic [2*XLEN-1:0]       rd_data1,
    input logic [RMW-1:0]          rmode_q,
    input logic                    fault
);
    localparam int FW = $clog2(NFP);

    AST_LOCKED_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_grp == 3'd1 && !load_mode) |=> fault); // R5

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault |-> $past((wr_en && wr_grp == 3'd1 && !load_mode) || (ld_we && !load_mode))); // R4

    AST_RMODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !rmode_we |=> $stable(rmode_q)); // R8

    AST_INT_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (rd_grp0 == 3'd0) |-> (rd_data0[2*XLEN-1:XLEN] == '0)); // R1

    AST_ACC_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_grp == 3'd2) |=>
        ((rd_grp1 == 3'd2 && rd_idx1[FW-1:0] == $past(wr_idx[FW-1:0])) -> (rd_data1 == $past(wr_data)))); // R6

    AST_BAD_GROUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_grp0 > 3'd4) |-> (rd_data0 == '0)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rmode_q == '0 && !fault)); // R7
endmodule

bind vmregs_bank vmrf_chk #(.XLEN(XLEN), .NINT(NINT), .NFP(NFP), .RMW(RMW)) u_chk (.*);

// File: tb/tb_vmregs_bank.sv
`timescale 1ns/1ps
module tb_vmregs_bank;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_mode = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_grp = '0;
    logic [2:0]   wr_idx = '0;
    logic [127:0] wr_data = '0;
    logic         ld_we = 1'b0;
    logic [1:0]   ld_idx = '0;
    logic [127:0] ld_data = '0;
    logic         rmode_we = 1'b0;
    logic [1:0]   rmode_d = '0;
    logic [2:0]   rd_grp0 = '0, rd_grp1 = '0;
    logic [2:0]   rd_idx0 = '0, rd_idx1 = '0;
    logic [127:0] rd_data0, rd_data1;
    logic [1:0]   rmode_q;
    logic         fault;

    vmregs_bank dut (.*);

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        int           kind;
        logic [127:0] exp;
        string        tag;
    } item_t;
    item_t sb[$];

    logic [63:0]  m_int  [8];
    logic [127:0] m_base [4];
    logic [127:0] m_acc  [4];
    logic [127:0] m_prod [4];
    logic [1:0]   m_rc;
    logic         m_err;

    logic         g_we, g_lwe, g_rwe, g_lm;
    logic [2:0]   g_grp, g_idx, g_rg0, g_ri0, g_rg1, g_ri1;
    logic [127:0] g_wd, g_ld;
    logic [1:0]   g_lidx, g_rv;

    function automatic logic [127:0] model_rd(logic [2:0] g, logic [2:0] i);
        case (g)
            3'd0: return {64'h0, m_int[i]};
            3'd1: return m_base[i[1:0]];
            3'd2: return m_acc[i[1:0]];
            3'd3: return m_prod[i[1:0]];
            3'd4: return i[2] ? m_prod[i[1:0]] : m_acc[i[1:0]];
            default: return '0;
        endcase
    endfunction

    task automatic set_wr(logic [2:0] g, logic [2:0] i, logic [127:0] d);
        g_we = 1'b1; g_grp = g; g_idx = i; g_wd = d;
    endtask

    task automatic set_ld(logic [1:0] i, logic [127:0] d);
        g_lwe = 1'b1; g_lidx = i; g_ld = d;
    endtask

    task automatic set_rd(logic [2:0] g0, logic [2:0] i0, logic [2:0] g1, logic [2:0] i1);
        g_rg0 = g0; g_ri0 = i0; g_rg1 = g1; g_ri1 = i1;
    endtask

    task automatic step(string tag);
        logic illegal;
        @(negedge clk);
        load_mode = g_lm;
        wr_en = g_we; wr_grp = g_grp; wr_idx = g_idx; wr_data = g_wd;
        ld_we = g_lwe; ld_idx = g_lidx; ld_data = g_ld;
        rmode_we = g_rwe; rmode_d = g_rv;
        rd_grp0 = g_rg0; rd_idx0 = g_ri0; rd_grp1 = g_rg1; rd_idx1 = g_ri1;
        sb.push_back('{0, model_rd(g_rg0, g_ri0), tag});
        sb.push_back('{1, model_rd(g_rg1, g_ri1), tag});
        sb.push_back('{2, {127'h0, m_err}, tag});
        sb.push_back('{3, {126'h0, m_rc}, tag});
        illegal = !g_lm && (g_lwe || (g_we && g_grp == 3'd1));
        if (g_lwe && g_lm) m_base[g_lidx] = g_ld;
        if (g_we) begin
            case (g_grp)
                3'd0: m_int[g_idx] = g_wd[63:0];
                3'd1: if (g_lm) m_base[g_idx[1:0]] = g_wd;
                3'd2: m_acc[g_idx[1:0]] = g_wd;
                3'd3: m_prod[g_idx[1:0]] = g_wd;
                3'd4: if (g_idx[2]) m_prod[g_idx[1:0]] = g_wd; else m_acc[g_idx[1:0]] = g_wd;
                default: ;
            endcase
        end
        if (g_rwe) m_rc = g_rv;
        m_err = illegal;
        g_we = 1'b0; g_lwe = 1'b0; g_rwe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0; ld_we = 1'b0; rmode_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) m_int[k] = '0;
        for (int k = 0; k < 4; k++) begin m_acc[k] = '0; m_prod[k] = '0; end
        m_rc = '0;
        m_err = 1'b0;
    endtask

    // monitor: pops expected items and compares them away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [127:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = rd_data0;
                    1: act = rd_data1;
                    2: act = {127'h0, fault};
                    default: act = {126'h0, rmode_q};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        g_we = 0; g_lwe = 0; g_rwe = 0; g_lm = 0;
        g_grp = 0; g_idx = 0; g_wd = 0; g_lidx = 0; g_ld = 0; g_rv = 0;
        g_rg0 = 0; g_ri0 = 0; g_rg1 = 0; g_ri1 = 0;
        for (int k = 0; k < 4; k++) m_base[k] = 'x;
        do_reset();

        // R7: reset state
        set_rd(3'd0, 3'd0, 3'd2, 3'd0); step("R7");
        set_rd(3'd3, 3'd3, 3'd0, 3'd7); step("R7");

        // R4: fill base bank during load phase
        g_lm = 1'b1;
        for (int k = 0; k < 4; k++) begin
            set_ld(k[1:0], {64'hB0B0_0000_0000_0000 + 64'(k), 64'h1111_0000 + 64'(k)});
            set_rd(3'd1, 3'(k), 3'd1, 3'(k));
            step("R4");
        end
        set_rd(3'd1, 3'd0, 3'd1, 3'd3); step("R4");
        set_wr(3'd1, 3'd1, {64'hC1, 64'hC2}); step("R4");
        set_rd(3'd1, 3'd1, 3'd1, 3'd2); step("R4");

        // R10: both ports on one base register
        set_ld(2'd2, {64'hDEAD, 64'h1});
        set_wr(3'd1, 3'd2, {64'hBEEF, 64'h2});
        step("R10");
        set_rd(3'd1, 3'd2, 3'd1, 3'd6); step("R10");
        g_lm = 1'b0;

        // R1: integer writes drop the upper half
        for (int k = 0; k < 8; k++) begin
            set_wr(3'd0, 3'(k), {64'hFFFF_EEEE_DDDD_CCCC, 64'h5000_0000_0000_0000 + 64'(k * 3)});
            set_rd(3'd0, 3'(k), 3'd0, 3'((k + 7) % 8));
            step("R1");
        end
        set_rd(3'd0, 3'd7, 3'd0, 3'd4); step("R1");

        // R2: index bit 2 ignored for four-register banks
        set_wr(3'd2, 3'b101, {64'hACC1, 64'hACC1_0001}); step("R2");
        set_wr(3'd3, 3'b110, {64'h9902, 64'h9902_0002}); set_rd(3'd2, 3'd1, 3'd2, 3'd5); step("R2");
        set_rd(3'd3, 3'd2, 3'd3, 3'd6); step("R2");

        // R3: mixed view onto accumulate / product banks
        set_wr(3'd4, 3'd5, {64'h3131, 64'h5151}); step("R3");
        set_rd(3'd3, 3'd1, 3'd4, 3'd5); step("R3");
        set_wr(3'd4, 3'd2, {64'h4242, 64'h2424}); step("R3");
        set_rd(3'd2, 3'd2, 3'd4, 3'd2); step("R3");
        set_rd(3'd4, 3'd6, 3'd4, 3'd1); step("R11");

        // R6: same-cycle read returns old data
        set_wr(3'd2, 3'd3, {64'h0606, 64'h6060});
        set_rd(3'd2, 3'd3, 3'd4, 3'd3); step("R6");
        step("R6");
        set_wr(3'd3, 3'd0, {64'h7777, 64'h8888});
        set_rd(3'd4, 3'd4, 3'd3, 3'd0); step("R6");
        step("R6");

        // R4/R5: locked base writes ignored, fault pulse
        set_wr(3'd1, 3'd0, {64'hBAD0, 64'hBAD0});
        set_rd(3'd1, 3'd0, 3'd1, 3'd1); step("R4");
        step("R5");
        step("R5");
        set_ld(2'd3, {64'hBAD1, 64'hBAD1}); step("R4");
        set_wr(3'd1, 3'd3, {64'hBAD2, 64'hBAD2}); set_rd(3'd1, 3'd3, 3'd0, 3'd0); step("R5");
        step("R5");
        step("R5");

        // R8: rounding mode
        g_rwe = 1'b1; g_rv = 2'd2; step("R8");
        step("R8");
        step("R8");
        g_rwe = 1'b1; g_rv = 2'd3; step("R8");
        step("R8");

        // R9: unused group codes
        set_wr(3'd6, 3'd1, {64'hE6E6, 64'hE6E6}); set_rd(3'd7, 3'd1, 3'd5, 3'd1); step("R9");
        set_rd(3'd0, 3'd1, 3'd2, 3'd1); step("R9");
        set_rd(3'd3, 3'd1, 3'd1, 3'd1); step("R9");

        // R7: second reset keeps base bank
        do_reset();
        set_rd(3'd1, 3'd1, 3'd2, 3'd1); step("R7");
        set_rd(3'd0, 3'd3, 3'd1, 3'd2); step("R7");
        set_rd(3'd4, 3'd4, 3'd3, 3'd1); step("R7");

        @(negedge clk);
        #5;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule